// File: doc/BRIEF.md
# Copying-Collector Pointer Load Barrier

This unit sits in the memory stage of a processor whose loads know which values are pointers. Every pointer coming back from a load is compared against the current fromspace window. A null pointer, or one outside the window, goes on to the register file unchanged in the same cycle.

A pointer inside the window stalls the pipeline. The unit then moves the object's header to tospace on its own, without an interrupt or a helper processor. The work happens in two phases:

- **Phase one** reads the object's attribute word. It reserves room in tospace by bumping the allocation register. It then overwrites the old attribute word with a tagged forwarding address.
- **Phase two** writes the new two-word header: the attribute word, then a backlink to the old location.

The tospace address replaces the loaded pointer. If the object was already forwarded, the stored address is returned directly and nothing is allocated.

Copying of object bodies, root scanning and the semispace flip belong to other logic. That logic reloads the allocation register through `freeSet` when a new cycle starts.

Top module: `read_barrier_unit`

## Requirements
- R1: When idle, a load with `ldPtr` zero, below `fromBase`, or at or above `fromLimit` gives `outValid`=`ldValid` and `outPtr`=`ldPtr` in the same cycle, with `stall` low and no memory request.
- R2: A non-zero load with `fromBase` <= `ldPtr` < `fromLimit` raises `stall` in the same cycle. `stall` stays high until the cycle in which `outValid` delivers the replacement, and in that cycle `stall` is low.
- R3: The first memory transfer of a fault is a read of the attribute word at the faulting address. No write is issued before that read is acknowledged.
- R4: Attribute word layout: bit 31 set means forwarded, and bits 30:0 hold the forwarding address. Otherwise bits 11:0 hold the pointer-slot count and bits 23:12 hold the data-slot count. For a forwarded word the unit returns the address in bits 30:0, writes nothing, and leaves `freeOut` unchanged.
- R5: For an unforwarded object, the tospace address is the old `freeOut` value. `freeOut` becomes old + 8 + pointer slots + data slots.
- R6: The first write goes to the faulting address with data {1'b1, tospace address bits 30:0}.
- R7: Two more writes follow, in this order: the original attribute word to the tospace address, then the faulting address (backlink) to the tospace address + 1.
- R8: After an evacuation, `outPtr` carries the tospace address while `outValid` is high.
- R9: If old free + 8 + slots exceeds `toLimit`:
  - `oomErr` is set and stays set;
  - no write is issued;
  - `freeOut` is unchanged;
  - the original pointer is returned.
- R10: `freeSet` loads `freeSetVal` into the allocation register and clears `oomErr`. After reset, `freeOut` is 0.
- R11: No barrier stall lasts more than 500 consecutive cycles (given an acknowledge within a few cycles).
- R12: The memory port moves one word per request/acknowledge pair, and holds `memReq`, `memWe`, `memAddr` and `memWdata` steady until `memAck`. A full evacuation takes exactly four transfers.
- R13: Once a fault is taken, changes on `ldPtr`/`ldValid` until the result is delivered have no effect. The evacuation uses the captured address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ldValid | input | 1 | Loaded pointer is present |
| ldPtr | input | 32 | Loaded pointer |
| fromBase | input | 32 | Lowest fromspace address (inclusive) |
| fromLimit | input | 32 | Fromspace end (exclusive) |
| toLimit | input | 32 | Highest allowed allocation end |
| freeSet | input | 1 | Load the allocation register |
| freeSetVal | input | 32 | Value for the allocation register |
| freeOut | output | 32 | Current allocation register |
| outValid | output | 1 | Pointer for the register file is valid |
| outPtr | output | 32 | Pointer for the register file |
| stall | output | 1 | Holds the pipeline |
| oomErr | output | 1 | Sticky tospace exhaustion flag |
| memReq | output | 1 | Memory request |
| memWe | output | 1 | Request is a write |
| memAddr | output | 32 | Word address |
| memWdata | output | 32 | Write data |
| memAck | input | 1 | Memory acknowledge, completes the transfer |
| memRdata | input | 32 | Read data, valid with `memAck` |

## Verification
Some rules are checked on every cycle:
- same-cycle pass-through of pointers outside the window;
- steady request signals until acknowledge;
- no write before the attribute read;
- stall ending only together with a delivered result;
- the 500-cycle stall bound;
- the allocation register holding its value when exhaustion is flagged.

Other properties depend on memory contents and on earlier loads, so only the bench scenarios can show them:
- the exact tospace address and allocation arithmetic;
- forwarded-object reuse on a second load of the same pointer;
- header and backlink contents in memory;
- inclusive and exclusive window edges;
- capture of the pointer despite later input changes.

// File: rtl/rb_pkg.sv
package rb_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_DECIDE,
    ST_FWD,
    ST_ATTR,
    ST_BACK,
    ST_DONE
  } rbState_e;

  typedef enum logic [1:0] {
    ADR_OBJ,
    ADR_NEW,
    ADR_BACK
  } adrSel_e;

  typedef struct packed {
    logic    capPtr;
    logic    capAttr;
    logic    commit;
    logic    flagOom;
    logic    takeFwd;
    logic    keepOld;
    adrSel_e adrSel;
  } rbCtrl_t;

endpackage

// File: rtl/rb_datapath.sv
module rb_datapath
  import rb_pkg::*;
#(
  parameter int W         = 32,
  parameter int SIZE_W    = 12,
  parameter int HDR_WORDS = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  rbCtrl_t       ctrl,
  input  logic [W-1:0]  ldPtr,
  input  logic [W-1:0]  fromBase,
  input  logic [W-1:0]  fromLimit,
  input  logic [W-1:0]  toLimit,
  input  logic          freeSet,
  input  logic [W-1:0]  freeSetVal,
  input  logic [W-1:0]  memRdata,
  output logic          faultHit,
  output logic          attrFwd,
  output logic          oomHit,
  output logic [W-1:0]  memAddr,
  output logic [W-1:0]  memWdata,
  output logic [W-1:0]  resultPtr,
  output logic [W-1:0]  freeOut,
  output logic          oomErr
);

  localparam int SUM_W = W + 1;

  logic [W-1:0]      objPtrQ;
  logic [W-1:0]      attrQ;
  logic [W-1:0]      newAddrQ;
  logic [W-1:0]      resultQ;
  logic [W-1:0]      freeQ;
  logic              oomQ;
  logic [SIZE_W-1:0] ptrSlots;
  logic [SIZE_W-1:0] dataSlots;
  logic [W-1:0]      fwdAddr;
  logic [SUM_W-1:0]  nextFree;

  // Window test: two magnitude comparators plus a null check.
  assign faultHit = (ldPtr != '0) && (ldPtr >= fromBase) && (ldPtr < fromLimit);

  // Attribute word fields.
  assign attrFwd   = attrQ[W-1];
  assign ptrSlots  = attrQ[SIZE_W-1:0];
  assign dataSlots = attrQ[2*SIZE_W-1:SIZE_W];
  assign fwdAddr   = {1'b0, attrQ[W-2:0]};

  // Allocation arithmetic, one bit wider so it cannot wrap.
  assign nextFree = {1'b0, freeQ} + SUM_W'(HDR_WORDS)
                  + SUM_W'(ptrSlots) + SUM_W'(dataSlots);
  assign oomHit   = nextFree > {1'b0, toLimit};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      objPtrQ  <= '0;
      attrQ    <= '0;
      newAddrQ <= '0;
      resultQ  <= '0;
      freeQ    <= '0;
      oomQ     <= 1'b0;
    end else begin
      if (ctrl.capPtr)  objPtrQ <= ldPtr;
      if (ctrl.capAttr) attrQ   <= memRdata;
      if (ctrl.takeFwd) resultQ <= fwdAddr;
      if (ctrl.keepOld) resultQ <= objPtrQ;
      if (ctrl.commit) begin
        newAddrQ <= freeQ;
        resultQ  <= freeQ;
      end
      if (freeSet) begin
        freeQ <= freeSetVal;
        oomQ  <= 1'b0;
      end else begin
        if (ctrl.commit)  freeQ <= nextFree[W-1:0];
        if (ctrl.flagOom) oomQ  <= 1'b1;
      end
    end
  end

  always_comb begin
    unique case (ctrl.adrSel)
      ADR_NEW: begin
        memAddr  = newAddrQ;
        memWdata = attrQ;
      end
      ADR_BACK: begin
        memAddr  = newAddrQ + W'(1);
        memWdata = objPtrQ;
      end
      default: begin
        memAddr  = objPtrQ;
        memWdata = {1'b1, newAddrQ[W-2:0]};
      end
    endcase
  end

  assign resultPtr = resultQ;
  assign freeOut   = freeQ;
  assign oomErr    = oomQ;

endmodule

// File: rtl/rb_control.sv
module rb_control
  import rb_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    ldValid,
  input  logic    faultHit,
  input  logic    attrFwd,
  input  logic    oomHit,
  input  logic    memAck,
  output rbCtrl_t ctrl,
  output logic    memReq,
  output logic    memWe,
  output logic    stall,
  output logic    outValid,
  output logic    useResult,
  output logic    busy
);

  rbState_e stateQ, stateD;

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    stateD      = stateQ;
    ctrl        = '0;
    ctrl.adrSel = ADR_OBJ;
    memReq      = 1'b0;
    memWe       = 1'b0;
    stall       = 1'b1;
    outValid    = 1'b0;
    useResult   = 1'b0;
    unique case (stateQ)
      ST_IDLE: begin
        if (ldValid && faultHit) begin
          ctrl.capPtr = 1'b1;
          stateD      = ST_READ;
        end else begin
          stall    = 1'b0;
          outValid = ldValid;
        end
      end
      ST_READ: begin
        memReq = 1'b1;
        if (memAck) begin
          ctrl.capAttr = 1'b1;
          stateD       = ST_DECIDE;
        end
      end
      ST_DECIDE: begin
        if (attrFwd) begin
          ctrl.takeFwd = 1'b1;
          stateD       = ST_DONE;
        end else if (oomHit) begin
          ctrl.flagOom = 1'b1;
          ctrl.keepOld = 1'b1;
          stateD       = ST_DONE;
        end else begin
          ctrl.commit = 1'b1;
          stateD      = ST_FWD;
        end
      end
      ST_FWD: begin
        memReq = 1'b1;
        memWe  = 1'b1;
        if (memAck) stateD = ST_ATTR;
      end
      ST_ATTR: begin
        memReq      = 1'b1;
        memWe       = 1'b1;
        ctrl.adrSel = ADR_NEW;
        if (memAck) stateD = ST_BACK;
      end
      ST_BACK: begin
        memReq      = 1'b1;
        memWe       = 1'b1;
        ctrl.adrSel = ADR_BACK;
        if (memAck) stateD = ST_DONE;
      end
      ST_DONE: begin
        stall     = 1'b0;
        outValid  = 1'b1;
        useResult = 1'b1;
        stateD    = ST_IDLE;
      end
      default: stateD = ST_IDLE;
    endcase
  end

  assign busy = (stateQ != ST_IDLE);

endmodule

// File: rtl/read_barrier_unit.sv
module read_barrier_unit
  import rb_pkg::*;
#(
  parameter int W         = 32,
  parameter int SIZE_W    = 12,
  parameter int HDR_WORDS = 8,
  parameter int MAX_STALL = 500
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         ldValid,
  input  logic [W-1:0] ldPtr,
  input  logic [W-1:0] fromBase,
  input  logic [W-1:0] fromLimit,
  input  logic [W-1:0] toLimit,
  input  logic         freeSet,
  input  logic [W-1:0] freeSetVal,
  output logic [W-1:0] freeOut,
  output logic         outValid,
  output logic [W-1:0] outPtr,
  output logic         stall,
  output logic         oomErr,
  output logic         memReq,
  output logic         memWe,
  output logic [W-1:0] memAddr,
  output logic [W-1:0] memWdata,
  input  logic         memAck,
  input  logic [W-1:0] memRdata
);

  rbCtrl_t      ctrl;
  logic         faultHit;
  logic         attrFwd;
  logic         oomHit;
  logic         useResult;
  logic         busy;
  logic [W-1:0] resultPtr;

  rb_control uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .ldValid   (ldValid),
    .faultHit  (faultHit),
    .attrFwd   (attrFwd),
    .oomHit    (oomHit),
    .memAck    (memAck),
    .ctrl      (ctrl),
    .memReq    (memReq),
    .memWe     (memWe),
    .stall     (stall),
    .outValid  (outValid),
    .useResult (useResult),
    .busy      (busy)
  );

  rb_datapath #(
    .W         (W),
    .SIZE_W    (SIZE_W),
    .HDR_WORDS (HDR_WORDS)
  ) uData (
    .clk        (clk),
    .rstN       (rstN),
    .ctrl       (ctrl),
    .ldPtr      (ldPtr),
    .fromBase   (fromBase),
    .fromLimit  (fromLimit),
    .toLimit    (toLimit),
    .freeSet    (freeSet),
    .freeSetVal (freeSetVal),
    .memRdata   (memRdata),
    .faultHit   (faultHit),
    .attrFwd    (attrFwd),
    .oomHit     (oomHit),
    .memAddr    (memAddr),
    .memWdata   (memWdata),
    .resultPtr  (resultPtr),
    .freeOut    (freeOut),
    .oomErr     (oomErr)
  );

  assign outPtr = useResult ? resultPtr : ldPtr;

endmodule

// File: rtl/rb_checker.sv
module rb_checker #(
  parameter int W         = 32,
  parameter int MAX_STALL = 500
) (
  input logic         clk,
  input logic         rstN,
  input logic         busy,
  input logic         ldValid,
  input logic [W-1:0] ldPtr,
  input logic [W-1:0] fromBase,
  input logic [W-1:0] fromLimit,
  input logic         outValid,
  input logic [W-1:0] outPtr,
  input logic         stall,
  input logic         memReq,
  input logic         memWe,
  input logic         memAck,
  input logic [W-1:0] memAddr,
  input logic [W-1:0] memWdata,
  input logic [W-1:0] freeOut,
  input logic         oomErr
);

  localparam int CW = $clog2(MAX_STALL + 2);

  logic [CW-1:0] stallRun;
  logic          readDone;
  logic          outside;

  assign outside = (ldPtr == '0) || (ldPtr < fromBase) || (ldPtr >= fromLimit);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stallRun <= '0;
      readDone <= 1'b0;
    end else begin
      if (!stall)                            stallRun <= '0;
      else if (stallRun != CW'(MAX_STALL + 1)) stallRun <= stallRun + CW'(1);
      if (outValid)                          readDone <= 1'b0;
      else if (memReq && memAck && !memWe)   readDone <= 1'b1;
    end
  end

  // R1: pointers outside the window pass straight through.
  assert_pass_through_R1: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && ldValid && outside) |-> (outValid && outPtr == ldPtr && !stall && !memReq));

  // R2: the stall ends only in the cycle that delivers a result.
  assert_stall_ends_R2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(stall) |-> outValid);

  // R3: no write before the attribute read has completed.
  assert_read_first_R3: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memWe) |-> readDone);

  // R9: the allocation register keeps its value when exhaustion is flagged.
  assert_oom_keeps_free_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(oomErr) |-> $stable(freeOut));

  // R11: bounded stall.
  assert_stall_bound_R11: assert property (@(posedge clk) disable iff (!rstN)
    stall |-> (stallRun < CW'(MAX_STALL)));

  // R12: a pending request holds steady until acknowledged.
  assert_req_steady_R12: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memWe) && $stable(memAddr) && $stable(memWdata)));

endmodule

bind read_barrier_unit rb_checker #(.W(W), .MAX_STALL(MAX_STALL)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .busy      (busy),
  .ldValid   (ldValid),
  .ldPtr     (ldPtr),
  .fromBase  (fromBase),
  .fromLimit (fromLimit),
  .outValid  (outValid),
  .outPtr    (outPtr),
  .stall     (stall),
  .memReq    (memReq),
  .memWe     (memWe),
  .memAck    (memAck),
  .memAddr   (memAddr),
  .memWdata  (memWdata),
  .freeOut   (freeOut),
  .oomErr    (oomErr)
);

// File: tb/sim_read_barrier_unit.sv
`timescale 1ns/1ps
module sim_read_barrier_unit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ldValid = 1'b0;
  logic [31:0] ldPtr = '0;
  logic [31:0] fromBase = 32'd16;
  logic [31:0] fromLimit = 32'd64;
  logic [31:0] toLimit = 32'd200;
  logic        freeSet = 1'b0;
  logic [31:0] freeSetVal = '0;
  logic [31:0] freeOut;
  logic        outValid;
  logic [31:0] outPtr;
  logic        stall;
  logic        oomErr;
  logic        memReq;
  logic        memWe;
  logic [31:0] memAddr;
  logic [31:0] memWdata;
  logic        memAck;
  logic [31:0] memRdata;

  int checks = 0;
  int failures = 0;
  int wrCount = 0;
  int xferCount = 0;
  int orderViol = 0;
  bit readSeen = 0;
  bit finished = 0;

  logic [31:0] mem [256];

  always #4 clk = ~clk;

  read_barrier_unit u0 (
    .clk(clk), .rstN(rstN), .ldValid(ldValid), .ldPtr(ldPtr),
    .fromBase(fromBase), .fromLimit(fromLimit), .toLimit(toLimit),
    .freeSet(freeSet), .freeSetVal(freeSetVal), .freeOut(freeOut),
    .outValid(outValid), .outPtr(outPtr), .stall(stall), .oomErr(oomErr),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memAck(memAck), .memRdata(memRdata)
  );

  // Word memory with a one-cycle acknowledge. It also watches transfer order.
  assign memRdata = mem[memAddr[7:0]];
  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 256; i++) mem[i] = '0;
      mem[20] = 32'h0000_3002;
      mem[30] = 32'h8000_004D;
      mem[40] = 32'h0000_1001;
      mem[16] = 32'h0000_0000;
      mem[50] = 32'h0000_0064;
      mem[45] = 32'h0000_2000;
      memAck  <= 1'b0;
      readSeen = 0;
    end else begin
      if (memReq && memAck) begin
        xferCount++;
        if (memWe) begin
          wrCount++;
          if (!readSeen) orderViol++;
          mem[memAddr[7:0]] = memWdata;
        end else begin
          readSeen = 1;
        end
        memAck <= 1'b0;
      end else begin
        memAck <= memReq;
      end
      if (outValid) readSeen = 0;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doLoad(input logic [31:0] p, input bit swap, input logic [31:0] alt,
                        output logic [31:0] got, output bit stalled, output int cyc);
    @(negedge clk);
    ldValid = 1'b1;
    ldPtr   = p;
    #1;
    stalled = stall;
    cyc = 0;
    while (!outValid && cyc < 1000) begin
      @(posedge clk);
      #1;
      cyc++;
      if (swap && cyc == 3) ldPtr = alt;
      if (!outValid && !stall) stalled = 0;
    end
    got = outPtr;
    @(negedge clk);
    ldValid = 1'b0;
    ldPtr   = '0;
  endtask

  // Each entry: pointer, expected delivered pointer, expected free afterwards.
  localparam logic [95:0] VEC [8] = '{
    {32'd5,  32'd5,   32'd100},
    {32'd0,  32'd0,   32'd100},
    {32'd64, 32'd64,  32'd100},
    {32'd20, 32'd100, 32'd113},
    {32'd20, 32'd100, 32'd113},
    {32'd30, 32'd77,  32'd113},
    {32'd16, 32'd113, 32'd121},
    {32'd40, 32'd121, 32'd131}
  };

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] got;
    bit          stalled;
    int          cyc;
    int          wr0;
    int          xf0;

    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    // R10: reset state
    check("R10 reset free", freeOut, 32'd0);
    check("R9 reset oom", {31'd0, oomErr}, 32'd0);
    check("R2 reset stall", {31'd0, stall}, 32'd0);
    check("R12 reset req", {31'd0, memReq}, 32'd0);

    @(negedge clk);
    freeSet = 1'b1;
    freeSetVal = 32'd100;
    @(negedge clk);
    freeSet = 1'b0;
    check("R10 free load", freeOut, 32'd100);

    for (int i = 0; i < 8; i++) begin
      logic [31:0] p;
      logic [31:0] eo;
      logic [31:0] ef;
      bit          inWin;
      {p, eo, ef} = VEC[i];
      inWin = (p != 0) && (p >= fromBase) && (p < fromLimit);
      wr0 = wrCount;
      xf0 = xferCount;
      doLoad(p, 1'b0, '0, got, stalled, cyc);
      check(inWin ? "R8 delivered pointer" : "R1 pass-through pointer", got, eo);
      check("R5 free after load", freeOut, ef);
      check(inWin ? "R2 stall raised" : "R1 no stall", {31'd0, stalled}, {31'd0, inWin});
      if (!inWin) check("R1 no transfer", xferCount - xf0, 0);
      else        check("R11 stall length", {31'd0, cyc < 500}, 32'd1);
      if (i == 3) begin
        check("R6 forwarding word", mem[20], 32'h8000_0064);
        check("R7 tospace attribute", mem[100], 32'h0000_3002);
        check("R7 backlink", mem[101], 32'd20);
        check("R12 four transfers", xferCount - xf0, 4);
      end
      if (i == 4 || i == 5) check("R4 forwarded: no writes", wrCount - wr0, 0);
      if (i == 6) check("R7 zero-size backlink", mem[114], 32'd16);
    end

    // R9: exhaustion
    wr0 = wrCount;
    doLoad(32'd50, 1'b0, '0, got, stalled, cyc);
    check("R9 original pointer", got, 32'd50);
    check("R9 oom flag", {31'd0, oomErr}, 32'd1);
    check("R9 free unchanged", freeOut, 32'd131);
    check("R9 no writes", wrCount - wr0, 0);
    check("R9 attribute kept", mem[50], 32'h0000_0064);
    doLoad(32'd3, 1'b0, '0, got, stalled, cyc);
    check("R9 flag sticky", {31'd0, oomErr}, 32'd1);

    // R10: reload clears the flag
    @(negedge clk);
    freeSet = 1'b1;
    freeSetVal = 32'd150;
    @(negedge clk);
    freeSet = 1'b0;
    check("R10 reload free", freeOut, 32'd150);
    check("R10 oom cleared", {31'd0, oomErr}, 32'd0);

    // R13: pointer input changes mid-stall are ignored
    doLoad(32'd45, 1'b1, 32'd3, got, stalled, cyc);
    check("R13 result", got, 32'd150);
    check("R13 free", freeOut, 32'd160);
    check("R13 backlink", mem[151], 32'd45);
    check("R6 forwarding word", mem[45], 32'h8000_0096);

    check("R3 write order", orderViol, 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule